// File: doc/BRIEF.md
# Serial Channel Block Receive Engine

This engine sits beside a byte-wide serial shifter and moves a programmed block of received bytes into memory with no processor help. Software loads a start address and a byte count into two registers, then writes one control word that asks for a receive in block-transfer mode. From then on the engine takes bytes from the shifter and packs each group of four into a 32-bit word, first byte most significant. Each run of eight words goes out as one 32-byte burst on a memory write port with a valid/ready handshake.

Software watches the go bit in the control word. That bit stays high from the start of the transfer until the last word of the last burst has been accepted by memory, and it then clears by itself. Transfers move whole 32-byte units to 32-byte boundaries. The five low bits of the programmed address and count are dropped. While a burst is waiting to drain, the engine holds back the shifter.

Top module: `sdma_rx_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ctrl_busy`, `mem_valid` and `rx_ready` are all low.
- R2: Registers are chosen by `reg_sel` (0 = address, 1 = byte count, 2 = control). A control write with bit 0 (go) = 1, bit 1 (block mode) = 1 and bits 3:2 (direction) = 00 (from device) starts a transfer when the engine is idle, and `ctrl_busy` is high in the next cycle. Any other control value leaves the engine idle.
- R3: The number of bursts is the byte count shifted right by 5. A count whose bursts number zero starts nothing.
- R4: The first burst goes to the programmed address with its five low bits forced to zero.
- R5: Bytes are packed big-endian. Of each four accepted bytes, the first lands in data bits 31:24 and the fourth in bits 7:0.
- R6: Each burst is eight beats at base+0, +4, … +28. The next burst base is 32 higher.
- R7: `rx_ready` is low while a burst is waiting on or draining to the memory port.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R9: `ctrl_busy` stays high until the last beat of the last burst is accepted and is low in the cycle after. Exactly count/32 bursts are written.
- R10: Register writes made while a transfer runs, including a second start, change nothing in that transfer.
- R11: `rx_ready` and `mem_valid` are low whenever `ctrl_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| reg_wdata | input | 32 | Register write data |
| ctrl_busy | output | 1 | Go bit readback, high while a transfer runs |
| rx_valid | input | 1 | Shifter offers a byte |
| rx_byte | input | 8 | Byte from the shifter |
| rx_ready | output | 1 | Engine takes the offered byte this cycle |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 32 | Beat data |

## Verification
Two events can land in the same clock edge: the memory port accepting the eighth beat of a burst, and the shifter offering the next byte. To provoke this, the bench keeps `rx_valid` high through the drain while `mem_ready` toggles at random. The offered byte must not be taken on that edge. It must be taken on a later edge and show up in bits 31:24 of word 0 of the next burst, and the burst address must have moved up by exactly 32. The bench predicts every beat's address and data from the byte index, so any byte that is lost or taken twice shifts all later words and is reported.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int BURST_BYTES = 32;
    localparam int WORD_BYTES  = 4;
    localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;
    localparam int BURST_SHIFT = $clog2(BURST_BYTES);
    localparam int BEAT_W      = $clog2(BURST_WORDS);
    localparam int LANE_W      = $clog2(WORD_BYTES);
    localparam int DATA_W      = 8 * WORD_BYTES;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    localparam logic [1:0] DIR_FROM_DEV = 2'b00;

    typedef struct packed {
        logic [27:0] rsvd;
        logic [1:0]  dir;
        logic        blk;
        logic        go;
    } ctrl_word_t;

    function automatic logic is_block_rx_start(input ctrl_word_t c);
        return c.go && c.blk && (c.dir == DIR_FROM_DEV);
    endfunction

endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  reg_sel_e          reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              burst_done,
    output logic              busy,
    output logic [ADDR_W-1:0] burst_base
);
    localparam int CNT_W = LEN_W - BURST_SHIFT;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BURST_BYTES - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] base_q;
    logic              busy_q;
    logic              start_req;
    logic [CNT_W-1:0]  start_cnt;

    assign start_cnt = CNT_W'(len_q >> BURST_SHIFT);
    assign start_req = reg_we && (reg_sel == SEL_CTRL) && !busy_q
                       && is_block_rx_start(ctrl_word_t'(reg_wdata))
                       && (start_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            len_q  <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
            if (reg_sel == SEL_LEN)  len_q  <= reg_wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            base_q <= '0;
            left_q <= '0;
        end else if (start_req) begin
            busy_q <= 1'b1;
            base_q <= addr_q & ALIGN_MASK;
            left_q <= start_cnt;
        end else if (busy_q && burst_done) begin
            base_q <= base_q + ADDR_W'(BURST_BYTES);
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) busy_q <= 1'b0;
        end
    end

    assign busy       = busy_q;
    assign burst_base = base_q;

endmodule

// File: rtl/sdma_packer.sv
module sdma_packer
    import sdma_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        busy,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_byte,
    input  logic                        drain_done,
    output logic                        rx_ready,
    output logic                        full,
    output logic [BURST_WORDS-1:0][DATA_W-1:0] words
);
    logic [LANE_W-1:0] lane_q;
    logic [BEAT_W-1:0] widx_q;
    logic              full_q;
    logic              take;
    logic              last_lane;
    logic              last_word;

    assign rx_ready  = busy && !full_q;
    assign take      = rx_valid && rx_ready;
    assign last_lane = (lane_q == LANE_W'(WORD_BYTES - 1));
    assign last_word = (widx_q == BEAT_W'(BURST_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            lane_q <= '0;
            widx_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (take) begin
                lane_q <= last_lane ? '0 : lane_q + 1'b1;
                if (last_lane) begin
                    widx_q <= last_word ? '0 : widx_q + 1'b1;
                    if (last_word) full_q <= 1'b1;
                end
            end
            if (drain_done) full_q <= 1'b0;
        end
    end

    for (genvar w = 0; w < BURST_WORDS; w++) begin : g_word
        for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (take && (widx_q == BEAT_W'(w)) && (lane_q == LANE_W'(l)))
                    words[w][8*(WORD_BYTES-1-l) +: 8] <= rx_byte;
            end
        end
    end

    assign full = full_q;

endmodule

// File: rtl/sdma_beat_writer.sv
module sdma_beat_writer
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               full,
    input  logic [BURST_WORDS-1:0][DATA_W-1:0] words,
    input  logic [ADDR_W-1:0]                  base,
    input  logic                               mem_ready,
    output logic                               mem_valid,
    output logic [ADDR_W-1:0]                  mem_addr,
    output word_t                              mem_data,
    output logic                               burst_done
);
    logic [BEAT_W-1:0] beat_q;
    logic              last_beat;
    logic              fire;

    assign mem_valid  = full;
    assign fire       = full && mem_ready;
    assign last_beat  = (beat_q == BEAT_W'(BURST_WORDS - 1));
    assign burst_done = fire && last_beat;
    assign mem_data   = words[beat_q];
    assign mem_addr   = base + ADDR_W'({beat_q, {LANE_W{1'b0}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (fire) begin
            beat_q <= last_beat ? '0 : beat_q + 1'b1;
        end
    end

endmodule

// File: rtl/sdma_rx_engine.sv
module sdma_rx_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              ctrl_busy,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data
);
    logic                               busy;
    logic                               full;
    logic                               burst_done;
    logic [ADDR_W-1:0]                  burst_base;
    logic [BURST_WORDS-1:0][DATA_W-1:0] words;

    sdma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel_e'(reg_sel)),
        .reg_wdata  (reg_wdata),
        .burst_done (burst_done),
        .busy       (busy),
        .burst_base (burst_base)
    );

    sdma_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .drain_done (burst_done),
        .rx_ready   (rx_ready),
        .full       (full),
        .words      (words)
    );

    sdma_beat_writer #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .full       (full),
        .words      (words),
        .base       (burst_base),
        .mem_ready  (mem_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .burst_done (burst_done)
    );

    assign ctrl_busy = busy;

endmodule

// File: rtl/sdma_rx_checker.sv
module sdma_rx_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              ctrl_busy,
    input logic              rx_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_data
);
    logic [31:0] len_shadow;
    logic        good_start;

    always_ff @(posedge clk) begin
        if (rst) len_shadow <= '0;
        else if (reg_we && reg_sel == 2'd1) len_shadow <= reg_wdata;
    end

    assign good_start = reg_we && (reg_sel == 2'd2) && (reg_wdata[3:0] == 4'b0011)
                        && ((len_shadow >> 5) != 0);

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!ctrl_busy && !mem_valid && !rx_ready));

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_busy && good_start) |=> ctrl_busy);

    p_no_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_busy && !good_start) |=> !ctrl_busy);

    p_word_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[1:0] == 2'b00));

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !rx_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !ctrl_busy |-> (!rx_ready && !mem_valid));

endmodule

bind sdma_rx_engine sdma_rx_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .ctrl_busy (ctrl_busy),
    .rx_ready  (rx_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
);

// File: tb/sdma_rx_engine_test.sv
`timescale 1ns/1ps
module sdma_rx_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        ctrl_busy;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdma_rx_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_busy(ctrl_busy), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int t, input int k);
        return 8'(k * 37 + t * 91 + (k >> 5) * 13);
    endfunction

    function automatic logic [31:0] exp_word(input int t, input int w);
        return {pat(t, 4*w), pat(t, 4*w+1), pat(t, 4*w+2), pat(t, 4*w+3)};
    endfunction

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_xfer(input logic [31:0] addr, input logic [31:0] len,
                           input int vpct, input int rpct, input bit disturb, input int t);
        int nb;
        int err0;
        logic [31:0] base;
        nb   = int'(len >> 5);
        base = {addr[31:5], 5'b0};
        err0 = errors;
        write_reg(2'd0, addr);
        write_reg(2'd1, len);
        write_reg(2'd2, 32'h3);
        chk(ctrl_busy == 1'b1, "R2 busy after valid start", 32'(ctrl_busy), 32'd1);
        fork
            begin : feed
                int k = 0;
                while (k < nb * 32) begin
                    @(negedge clk);
                    rx_valid = (($urandom % 100) < vpct);
                    rx_byte  = pat(t, k);
                    #1;
                    if (rx_valid && rx_ready) k++;
                end
                @(negedge clk);
                rx_valid = 1'b0;
            end
            begin : mon
                int w = 0;
                bit held = 1'b0;
                logic [31:0] h_addr = '0;
                logic [31:0] h_data = '0;
                while (w < nb * 8) begin
                    @(negedge clk);
                    mem_ready = (($urandom % 100) < rpct);
                    #1;
                    if (held) begin
                        chk(mem_valid && mem_addr == h_addr, "R8 address held", mem_addr, h_addr);
                        chk(mem_data == h_data, "R8 data held", mem_data, h_data);
                    end
                    held = 1'b0;
                    if (mem_valid) chk(rx_ready == 1'b0, "R7 shifter stalled", 32'(rx_ready), 32'd0);
                    if (mem_valid && !mem_ready) begin
                        held = 1'b1; h_addr = mem_addr; h_data = mem_data;
                    end
                    if (mem_valid && mem_ready) begin
                        chk(mem_addr == base + 32'(4 * w), "R4 R6 beat address", mem_addr, base + 32'(4 * w));
                        chk(mem_data == exp_word(t, w), "R5 packed word", mem_data, exp_word(t, w));
                        chk(ctrl_busy == 1'b1, "R9 busy during transfer", 32'(ctrl_busy), 32'd1);
                        w++;
                    end
                end
                @(negedge clk);
                mem_ready = 1'b0;
                chk(ctrl_busy == 1'b0, "R9 busy clears after last beat", 32'(ctrl_busy), 32'd0);
                chk(mem_valid == 1'b0, "R9 no extra burst", 32'(mem_valid), 32'd0);
                chk(rx_ready == 1'b0, "R11 idle not ready", 32'(rx_ready), 32'd0);
            end
            begin : poke
                if (disturb) begin
                    repeat (12) @(negedge clk);
                    write_reg(2'd0, 32'h0BAD_0000);
                    write_reg(2'd1, 32'h0000_4000);
                    write_reg(2'd2, 32'h3);
                end
            end
        join
        if (disturb)
            chk(errors == err0, "R10 transfer unaffected by writes", 32'(errors), 32'(err0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!ctrl_busy && !mem_valid && !rx_ready, "R1 idle in reset",
            {29'd0, ctrl_busy, mem_valid, rx_ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ctrl_busy && !mem_valid && !rx_ready, "R1 idle after reset",
            {29'd0, ctrl_busy, mem_valid, rx_ready}, 32'd0);

        write_reg(2'd0, 32'h0000_0100);
        write_reg(2'd1, 32'd64);
        write_reg(2'd2, 32'h1);
        chk(ctrl_busy == 1'b0, "R2 go without block mode", 32'(ctrl_busy), 32'd0);
        write_reg(2'd2, 32'h2);
        chk(ctrl_busy == 1'b0, "R2 block mode without go", 32'(ctrl_busy), 32'd0);
        write_reg(2'd2, 32'h7);
        chk(ctrl_busy == 1'b0, "R2 direction 01 rejected", 32'(ctrl_busy), 32'd0);
        write_reg(2'd2, 32'hB);
        chk(ctrl_busy == 1'b0, "R2 direction 10 rejected", 32'(ctrl_busy), 32'd0);
        rx_valid = 1'b1;
        #1;
        chk(rx_ready == 1'b0 && mem_valid == 1'b0, "R11 idle ignores shifter",
            {30'd0, rx_ready, mem_valid}, 32'd0);
        rx_valid = 1'b0;

        write_reg(2'd1, 32'd31);
        write_reg(2'd2, 32'h3);
        chk(ctrl_busy == 1'b0, "R3 zero-burst count starts nothing", 32'(ctrl_busy), 32'd0);

        do_xfer(32'h0000_1000, 32'd32, 100, 100, 1'b0, 1);
        do_xfer(32'h0000_2013, 32'h0000_005F, 100, 100, 1'b0, 2);
        do_xfer(32'h0000_3000, 32'd96, 100, 20, 1'b0, 3);
        do_xfer(32'h0000_4000, 32'd128, 70, 60, 1'b1, 4);

        for (int i = 0; i < 8; i++) begin
            logic [31:0] a;
            logic [31:0] l;
            a = $urandom;
            l = ((1 + $urandom % 5) * 32) | ($urandom % 32);
            do_xfer(a, l, 30 + int'($urandom % 71), 20 + int'($urandom % 81), 1'b0, 10 + i);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule